// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts down in ticks made by a clock prescaler. Software sets a 10-bit start value, starts and stops counting with a halt bit, and restarts the count with a kick. It can read the live count at any time. When the count runs out for the first time, the block sets a sticky timeout flag, reloads the counter and may raise an interrupt. If the flag has not been cleared by the next expiry, the block records a second-timeout event and emits a one-cycle system reset request.

A no-reboot bit can mask that reset request, so the second timeout is only recorded. When the reset is not masked, a boot-status flag marks that the watchdog caused the reset. Only power-on reset clears this flag, apart from software. Status flags are sticky and are cleared by writing 1 to them. Software reaches the block through a single-cycle synchronous register bus. Writes take effect at the clock edge. The read data is a combinational function of the address.

Top module: `two_stage_watchdog`

## Requirements
- R1: After power-on reset the control register reads 0x0801 (halt bit 11 set, no-reboot bit 0 set). The start value and the live count both read 4. Both status registers and the interrupt-enable register read 0, and `irq_o` and `sys_rst_o` are low.
- R2: A write to the start-value register (address 1) stores bits [9:0] only. Bits [15:10] read as 0 whatever value is written.
- R3: A start-value write with bits [9:0] in the range 0 to 3 is ignored, and the stored value is unchanged.
- R4: Writing exactly 0x0001 to the reload register (address 0) loads the live count with the start value. Any other value written there has no effect. A write to the start value alone does not change the count. Reading address 0 returns the live count in bits [9:0].
- R5: Control bit 11 (address 4) halts the count when it is 1. A kick while halted still loads the count, but the count stays frozen until the halt bit is cleared.
- R6: While running, the count drops by one every TICK_DIV clocks. A kick restarts the prescaler, so the next drop comes a full TICK_DIV clocks after the kick.
- R7: When the count is 1 and a tick arrives, that is an expiry. The count reloads to the start value. If the timeout flag (address 2, bit 3) is clear, it is set.
- R8: An expiry while the timeout flag is already set sets the second-timeout flag (address 3, bit 1). With no-reboot at 0, it also sets the boot flag (address 3, bit 2) and drives `sys_rst_o` high for exactly one cycle.
- R9: With no-reboot at 1, a second expiry sets the second-timeout flag but leaves `sys_rst_o` low and the boot flag clear.
- R10: Status flags clear only when 1 is written to their bit position. Writing 0 leaves them set.
- R11: `irq_o` rises on a first expiry only if interrupt-enable bit 13 (address 5) is set. It stays high until the timeout flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the current address |
| irq_o | output | 1 | Interrupt request, level |
| sys_rst_o | output | 1 | System reset request, one-cycle pulse |

## Verification
A register write takes effect at the clock edge that samples it. The read data then follows the address with no delay, so the bench compares read data one nanosecond after driving the address. A halt release or kick at edge E gives the first count drop at edge E+TICK_DIV and an expiry at edge E+start×TICK_DIV. Status, interrupt and reset pulse are all registered at that expiry edge. The bench waits an exact number of falling edges from the write and checks once at the cycle before the due edge and once at the due edge. The reset pulse is checked high at that edge and low one cycle later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 10;

  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_START  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT2  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd5;

  localparam int B_TMO   = 3;
  localparam int B_SEC   = 1;
  localparam int B_BOOT  = 2;
  localparam int B_HALT  = 11;
  localparam int B_NRB   = 0;
  localparam int B_IRQEN = 13;

  localparam logic [DATA_W-1:0] KICK_CODE = 16'h0001;
  localparam logic [CNT_W-1:0]  MIN_LOAD  = 10'd4;
  localparam logic [CNT_W-1:0]  RST_LOAD  = 10'd4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 150_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;

  always_comb begin
    pre_d  = pre_q;
    tick_o = 1'b0;
    pre_en = restart_i | run_i;
    if (restart_i) begin
      pre_d = '0;
    end else if (run_i) begin
      if (pre_q == LAST) begin
        pre_d  = '0;
        tick_o = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    cnt_en   = kick_i | tick_i;
    if (kick_i) begin
      cnt_d = load_i;
    end else if (tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        expire_o = 1'b1;
        cnt_d    = load_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  start_o,
  output logic              halt_o,
  output logic              nrb_o,
  output logic              kick_o,
  output logic              tmo_o,
  output logic              sec_o,
  output logic              boot_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] start_q, start_d;
  logic halt_q, halt_d, nrb_q, nrb_d, ien_q, ien_d;
  logic tmo_q, tmo_d, sec_q, sec_d, boot_q, boot_d, irq_q, irq_d, rst_q, rst_d;
  logic wr_start, wr_ctrl, wr_ien, wr_s1, wr_s2;
  logic first_exp, second_exp;

  always_comb begin
    wr_start   = wr_i && (addr_i == A_START);
    wr_ctrl    = wr_i && (addr_i == A_CTRL);
    wr_ien     = wr_i && (addr_i == A_IRQEN);
    wr_s1      = wr_i && (addr_i == A_STAT1);
    wr_s2      = wr_i && (addr_i == A_STAT2);
    kick_o     = wr_i && (addr_i == A_RELOAD) && (wdata_i == KICK_CODE);
    first_exp  = expire_i && !tmo_q;
    second_exp = expire_i && tmo_q;

    start_d = start_q;
    if (wr_start && (wdata_i[CNT_W-1:0] >= MIN_LOAD)) start_d = wdata_i[CNT_W-1:0];

    halt_d = halt_q;
    nrb_d  = nrb_q;
    if (wr_ctrl) begin
      halt_d = wdata_i[B_HALT];
      nrb_d  = wdata_i[B_NRB];
    end
    ien_d = wr_ien ? wdata_i[B_IRQEN] : ien_q;

    tmo_d = tmo_q;
    irq_d = irq_q;
    if (wr_s1 && wdata_i[B_TMO]) begin
      tmo_d = 1'b0;
      irq_d = 1'b0;
    end
    if (first_exp) begin
      tmo_d = 1'b1;
      if (ien_q) irq_d = 1'b1;
    end

    sec_d  = sec_q;
    boot_d = boot_q;
    if (wr_s2 && wdata_i[B_SEC])  sec_d  = 1'b0;
    if (wr_s2 && wdata_i[B_BOOT]) boot_d = 1'b0;
    if (second_exp) sec_d = 1'b1;
    rst_d = second_exp && !nrb_q;
    if (rst_d) boot_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= RST_LOAD;
      halt_q  <= 1'b1;
      nrb_q   <= 1'b1;
      ien_q   <= 1'b0;
      tmo_q   <= 1'b0;
      irq_q   <= 1'b0;
      sec_q   <= 1'b0;
      boot_q  <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (wr_start) start_q <= start_d;
      if (wr_ctrl) begin
        halt_q <= halt_d;
        nrb_q  <= nrb_d;
      end
      if (wr_ien) ien_q <= ien_d;
      if (wr_s1 || first_exp) begin
        tmo_q <= tmo_d;
        irq_q <= irq_d;
      end
      if (wr_s2 || second_exp) begin
        sec_q  <= sec_d;
        boot_q <= boot_d;
      end
      rst_q <= rst_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RELOAD: rdata_o[CNT_W-1:0] = cnt_i;
      A_START:  rdata_o[CNT_W-1:0] = start_q;
      A_STAT1:  rdata_o[B_TMO]     = tmo_q;
      A_STAT2: begin
        rdata_o[B_SEC]  = sec_q;
        rdata_o[B_BOOT] = boot_q;
      end
      A_CTRL: begin
        rdata_o[B_HALT] = halt_q;
        rdata_o[B_NRB]  = nrb_q;
      end
      A_IRQEN:  rdata_o[B_IRQEN]   = ien_q;
      default:  rdata_o            = '0;
    endcase
  end

  assign start_o   = start_q;
  assign halt_o    = halt_q;
  assign nrb_o     = nrb_q;
  assign tmo_o     = tmo_q;
  assign sec_o     = sec_q;
  assign boot_o    = boot_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/two_stage_watchdog.sv
module two_stage_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 150_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [1:0]       rsync_q;
  logic             rst_n;
  logic             tick, kick, expire, halt, nrb, tmo, sec, boot;
  logic [CNT_W-1:0] cnt, start_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  wdt_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(!halt), .restart_i(kick), .tick_o(tick)
  );

  wdt_countdown u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .load_i(start_val), .cnt_o(cnt), .expire_o(expire)
  );

  wdt_regfile u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .cnt_i(cnt), .expire_i(expire),
    .start_o(start_val), .halt_o(halt), .nrb_o(nrb), .kick_o(kick),
    .tmo_o(tmo), .sec_o(sec), .boot_o(boot), .irq_o(irq_o), .rst_req_o(sys_rst_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n,
  input logic             sys_rst_o,
  input logic             irq_o,
  input logic             halt,
  input logic             nrb,
  input logic             kick,
  input logic             expire,
  input logic             tmo,
  input logic             sec,
  input logic             boot,
  input logic [CNT_W-1:0] cnt
);
  assert_rst_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  assert_rst_sets_boot_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |-> boot && sec);
  assert_second_recorded_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    expire && tmo |=> sec);
  assert_noreboot_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |-> !$past(nrb));
  assert_halt_freezes_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(halt) && !$past(kick) |-> $stable(cnt));
  assert_count_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt != '0);
  assert_first_sets_tmo_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    expire |=> tmo);
  assert_irq_needs_tmo_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> tmo);
endmodule

bind two_stage_watchdog wdt_checker u_wdt_checker (
  .clk_i(clk_i), .rst_n(rst_n), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
  .halt(halt), .nrb(nrb), .kick(kick), .expire(expire),
  .tmo(tmo), .sec(sec), .boot(boot), .cnt(cnt)
);

// File: tb/test_two_stage_watchdog.sv
module test_two_stage_watchdog;
  localparam int DIV = 4;
  localparam int NV  = 22;
  localparam logic [2:0] AR = 3'd0, AS = 3'd1, A1 = 3'd2, A2 = 3'd3, AC = 3'd4, AI = 3'd5;

  // {write, addr, data, expected}
  localparam logic [35:0] VECS [NV] = '{
    {1'b0, AS, 16'h0000, 16'h0004},  // R1
    {1'b0, AC, 16'h0000, 16'h0801},  // R1
    {1'b0, A1, 16'h0000, 16'h0000},  // R1
    {1'b0, A2, 16'h0000, 16'h0000},  // R1
    {1'b0, AI, 16'h0000, 16'h0000},  // R1
    {1'b0, AR, 16'h0000, 16'h0004},  // R1
    {1'b1, AS, 16'hFC07, 16'h0000},
    {1'b0, AS, 16'h0000, 16'h0007},  // R2
    {1'b1, AS, 16'h0003, 16'h0000},
    {1'b0, AS, 16'h0000, 16'h0007},  // R3
    {1'b1, AS, 16'h0000, 16'h0000},
    {1'b0, AS, 16'h0000, 16'h0007},  // R3
    {1'b0, AR, 16'h0000, 16'h0004},  // R4 start write leaves count
    {1'b1, AR, 16'h0002, 16'h0000},
    {1'b0, AR, 16'h0000, 16'h0004},  // R4 non-kick code
    {1'b1, AR, 16'h0001, 16'h0000},
    {1'b0, AR, 16'h0000, 16'h0007},  // R4 kick
    {1'b1, A1, 16'h0008, 16'h0000},
    {1'b0, A1, 16'h0000, 16'h0000},  // R10
    {1'b1, AI, 16'hFFFF, 16'h0000},
    {1'b0, AI, 16'h0000, 16'h2000},  // R11 enable bit position
    {1'b1, AI, 16'h0000, 16'h0000}
  };

  logic        clk, rst_n, wr;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq, srst;
  int vectors = 0, miscompares = 0, rst_pulses = 0;
  bit done = 0;

  two_stage_watchdog #(.TICK_DIV(DIV)) i_two_stage_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (srst) rst_pulses++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(3);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rst", {15'b0, srst}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][35]) wr_reg(VECS[i][34:32], VECS[i][31:16]);
      else rd_reg($sformatf("vector %0d", i), VECS[i][34:32], VECS[i][15:0]);
    end

    // R5: kick while halted loads but stays frozen
    wr_reg(AS, 16'h0006);
    wr_reg(AR, 16'h0001);
    rd_reg("R5 kick halted", AR, 16'h0006);
    wait_edges(12);
    rd_reg("R5 frozen", AR, 16'h0006);

    // R6/R7/R11: run, interrupt disabled, no-reboot kept
    wr_reg(AC, 16'h0001);               // edge E
    wait_edges(3);
    rd_reg("R6 before tick", AR, 16'h0006);
    wait_edges(1);
    rd_reg("R6 first tick", AR, 16'h0005);
    wait_edges(19);
    rd_reg("R7 before expiry", A1, 16'h0000);
    wait_edges(1);
    rd_reg("R7 timeout set", A1, 16'h0008);
    rd_reg("R7 reload", AR, 16'h0006);
    chk("R11 gated off", {15'b0, irq}, 16'h0);

    // R9: second expiry masked
    wait_edges(24);
    rd_reg("R9 second recorded", A2, 16'h0002);
    chk("R9 no reset", 16'(rst_pulses), 16'h0);

    // R10: write-1-to-clear
    wr_reg(A2, 16'h0000);
    rd_reg("R10 zero write", A2, 16'h0002);
    wr_reg(A2, 16'h0002);
    rd_reg("R10 cleared", A2, 16'h0000);
    wr_reg(A1, 16'h0000);
    rd_reg("R10 zero write s1", A1, 16'h0008);
    wr_reg(A1, 16'h0008);
    rd_reg("R10 cleared s1", A1, 16'h0000);

    // R8/R11: reset path with interrupt enabled
    wr_reg(AI, 16'h2000);
    wr_reg(AC, 16'h0000);
    wr_reg(AR, 16'h0001);               // edge K, restarts prescaler (R6)
    wait_edges(23);
    chk("R11 before expiry", {15'b0, irq}, 16'h0);
    wait_edges(1);
    chk("R11 irq raised", {15'b0, irq}, 16'h1);
    rd_reg("R7 timeout again", A1, 16'h0008);
    wait_edges(23);
    chk("R8 no early reset", {15'b0, srst}, 16'h0);
    wait_edges(1);
    chk("R8 reset pulse", {15'b0, srst}, 16'h1);
    rd_reg("R8 second and boot", A2, 16'h0006);
    wait_edges(1);
    chk("R8 pulse ends", {15'b0, srst}, 16'h0);
    chk("R8 pulse count", 16'(rst_pulses), 16'h1);
    wr_reg(A1, 16'h0008);
    chk("R11 irq cleared", {15'b0, irq}, 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule